// File: doc/BRIEF.md
# SPI Slave Register Access Port

This block is an SPI slave that lets an external master read and write a bank of sixteen 8-bit registers. Each transaction is two bytes long and framed by an active-low chip select. The master first sends an instruction byte that holds a 7-bit register address in its upper bits and a read flag in bit 0. It then sends a data byte. Bits travel most significant first in both directions. The master's outgoing bits are sampled on the rising serial clock edge, and the slave's return line changes on the falling edge. During the instruction byte the slave returns zeros. During the second byte it returns the addressed register.

The block is transport only and knows nothing about what the registers mean. It oversamples chip select, serial clock and serial data-in with a faster system clock, through two-flop synchronizers. It presents a plain internal register bus: an address, a one-cycle write strobe, write data, and a combinational read-data return.

The serial clock must stay high for at least three system clocks and low for at least three system clocks.

Top module: `spi_reg_port`

## Requirements
- R1: After reset, and whenever chip select is high, `spi_miso` is 0 and `reg_wr` stays 0.
- R2: The first byte is the instruction, received MSB first on rising SCK edges. Bits [7:1] are the register address and bit [0] is 1 for a read and 0 for a write.
- R3: During the first byte, every bit returned on `spi_miso` is 0.
- R4: In a read, the addressed register value is returned MSB first during the second byte. `spi_miso` changes only after falling SCK edges. The value is captured from the register bus once, when the instruction byte completes.
- R5: In a write, `reg_wr` pulses high for exactly one system clock after all eight bits of the second byte have arrived. During that pulse, `reg_addr` holds address bits [3:0] and `reg_wdata` holds the second byte. There is exactly one pulse per transaction.
- R6: In a read, the second byte is ignored: no strobe is issued and no register changes.
- R7: Addresses 16 to 127 read as 0x00, and writes to them issue no strobe.
- R8: If chip select rises before both bytes are complete, the partial transaction is discarded with no strobe. The next transaction starts from its first bit.
- R9: Bits clocked in after the second byte, while chip select stays low, are ignored. No further strobe is issued and `spi_miso` returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Chip select, active low, asynchronous |
| spi_sck | input | 1 | Serial clock from master, asynchronous |
| spi_mosi | input | 1 | Serial data from master |
| spi_miso | output | 1 | Serial data to master |
| reg_addr | output | 4 | Register bus address |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_wdata | output | 8 | Write data |
| reg_rdata | input | 8 | Read data for `reg_addr` |

## Verification
The bench attacks the address-decode boundaries. It writes register 15 and reads it back. It writes address 16, which would alias onto register 0 if the upper address bits were dropped; register 0 is then read to show it is unchanged. A read instruction followed by a 0xFF data byte must not write anything. A design that ignored the read flag would overwrite the register.

Truncated frames of 5 and 12 bits must leave no strobe behind. A following full read then exposes a bit counter that failed to reset, because that read would come back shifted.

A 24-bit frame checks that trailing bits neither produce a second strobe nor re-send data. Throughout, every write strobe is compared cycle by cycle against a queue of expected writes, so a doubled, late or spurious pulse is reported.

// File: rtl/spi_reg_port.sv
module spi_reg_port #(
  parameter int FRAME_W     = 8,
  parameter int REG_COUNT   = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         spi_cs_n,
  input  logic                         spi_sck,
  input  logic                         spi_mosi,
  output logic                         spi_miso,
  output logic [$clog2(REG_COUNT)-1:0] reg_addr,
  output logic                         reg_wr,
  output logic [FRAME_W-1:0]           reg_wdata,
  input  logic [FRAME_W-1:0]           reg_rdata
);
  localparam int AW      = $clog2(REG_COUNT);
  localparam int FIELD_W = FRAME_W - 1;
  localparam int CNT_W   = $clog2(FRAME_W);

  typedef enum logic [1:0] {PH_INSTR, PH_DATA, PH_DONE} phase_t;

  logic [SYNC_STAGES-1:0] cs_pipe, sck_pipe, mosi_pipe;
  logic                   sck_d;
  logic                   cs_s, sck_s, mosi_s, sck_rise, sck_fall, frame_end, in_range;
  phase_t                 phase;
  logic [CNT_W-1:0]       bit_cnt;
  logic [FRAME_W-2:0]     rx_shift;
  logic [FRAME_W-1:0]     rx_next, tx_shift, wdata_q;
  logic [FIELD_W-1:0]     addr_q;
  logic                   rd_q, load_pend, miso_q, wr_q;

  assign cs_s      = cs_pipe[SYNC_STAGES-1];
  assign sck_s     = sck_pipe[SYNC_STAGES-1];
  assign mosi_s    = mosi_pipe[SYNC_STAGES-1];
  assign sck_rise  = !cs_s && sck_s && !sck_d;
  assign sck_fall  = !cs_s && !sck_s && sck_d;
  assign rx_next   = {rx_shift, mosi_s};
  assign frame_end = sck_rise && (bit_cnt == CNT_W'(FRAME_W - 1)) && (phase != PH_DONE);
  assign in_range  = {{(32-FIELD_W){1'b0}}, addr_q} < 32'(REG_COUNT);

  assign spi_miso  = miso_q;
  assign reg_addr  = addr_q[AW-1:0];
  assign reg_wr    = wr_q;
  assign reg_wdata = wdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_pipe   <= '1;
      sck_pipe  <= '0;
      mosi_pipe <= '0;
      sck_d     <= 1'b0;
    end else begin
      cs_pipe   <= {cs_pipe[SYNC_STAGES-2:0], spi_cs_n};
      sck_pipe  <= {sck_pipe[SYNC_STAGES-2:0], spi_sck};
      mosi_pipe <= {mosi_pipe[SYNC_STAGES-2:0], spi_mosi};
      sck_d     <= sck_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_INSTR;
      bit_cnt   <= '0;
      rx_shift  <= '0;
      addr_q    <= '0;
      rd_q      <= 1'b0;
      load_pend <= 1'b0;
      tx_shift  <= '0;
      miso_q    <= 1'b0;
      wr_q      <= 1'b0;
      wdata_q   <= '0;
    end else if (cs_s) begin
      phase     <= PH_INSTR;
      bit_cnt   <= '0;
      rx_shift  <= '0;
      load_pend <= 1'b0;
      tx_shift  <= '0;
      miso_q    <= 1'b0;
      wr_q      <= 1'b0;
    end else begin
      wr_q      <= 1'b0;
      load_pend <= 1'b0;
      if (sck_rise && phase != PH_DONE) begin
        rx_shift <= rx_next[FRAME_W-2:0];
        bit_cnt  <= frame_end ? '0 : bit_cnt + 1'b1;
      end
      if (frame_end) begin
        if (phase == PH_INSTR) begin
          addr_q    <= rx_next[FRAME_W-1:1];
          rd_q      <= rx_next[0];
          load_pend <= 1'b1;
          phase     <= PH_DATA;
        end else begin
          phase <= PH_DONE;
          if (!rd_q && in_range) begin
            wr_q    <= 1'b1;
            wdata_q <= rx_next;
          end
        end
      end
      if (sck_fall) begin
        miso_q   <= tx_shift[FRAME_W-1];
        tx_shift <= tx_shift << 1;
      end
      if (load_pend)
        tx_shift <= (rd_q && in_range) ? reg_rdata : '0;
    end
  end

  p_wr_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !reg_wr);

  p_wr_not_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> !rd_q);

  p_wr_inside_frame_r1: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> $past(!cs_s));

  p_miso_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_s && !sck_fall) |=> $stable(spi_miso));

  p_pad_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_INSTR) |-> !spi_miso);

  p_done_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DONE && $past(phase == PH_DONE)) |-> !reg_wr);
endmodule

// File: tb/tb_spi_reg_port.sv
module tb_spi_reg_port;
  localparam int HALF = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1, sck = 1'b0, mosi = 1'b0;
  logic       miso, reg_wr;
  logic [3:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic [7:0] bank [16];
  logic [7:0] model [16];
  logic [11:0] wq [$];
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  spi_reg_port dut (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sck(sck), .spi_mosi(mosi),
    .spi_miso(miso), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata)
  );

  function automatic logic [7:0] init_val(int i);
    return 8'(8'h30 + i * 7);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) bank[i] <= init_val(i);
    end else if (reg_wr) begin
      bank[reg_addr] <= reg_wdata;
    end
  end
  assign reg_rdata = bank[reg_addr];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && reg_wr) begin
      if (wq.size() == 0) chk("R5/R6/R7 unexpected strobe", {reg_addr, reg_wdata}, 32'hFFFF_FFFF);
      else chk("R5 strobe addr/data", {reg_addr, reg_wdata}, wq.pop_front());
    end
  end

  task automatic xfer(input logic [23:0] mo, input int nbits, output logic [23:0] mi);
    mi = '0;
    @(negedge clk) cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int k = 0; k < nbits; k++) begin
      mosi = mo[23-k];
      repeat (HALF) @(negedge clk);
      mi[23-k] = miso;
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic txn(input logic [6:0] addr, input logic rd, input logic [7:0] d2,
                     input logic [7:0] d3, input int nbits);
    logic [23:0] mi;
    logic [7:0]  exp_rd;
    exp_rd = (rd && addr < 16) ? model[addr[3:0]] : 8'h00;
    if (!rd && addr < 16 && nbits >= 16) begin
      wq.push_back({addr[3:0], d2});
      model[addr[3:0]] = d2;
    end
    xfer({addr, rd, d2, d3}, nbits, mi);
    if (nbits >= 8)  chk("R3 pad byte", mi[23:16], 8'h00);
    if (nbits >= 16 && rd) chk("R2/R4/R7 read data", mi[15:8], exp_rd);
    if (nbits >= 24) chk("R9 trailing byte", mi[7:0], 8'h00);
    chk("R5/R8 pending writes", wq.size(), 0);
    chk("R1 idle miso", miso, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) model[i] = init_val(i);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 reset miso", miso, 1'b0);
    chk("R1 reset strobe", reg_wr, 1'b0);
    for (int a = 0; a < 4; a++) txn(7'(a), 1'b1, 8'h00, 8'h00, 16);
    txn(7'd5, 1'b0, 8'hA5, 8'h00, 16);
    txn(7'd5, 1'b1, 8'h00, 8'h00, 16);
    txn(7'd15, 1'b0, 8'h3C, 8'h00, 16);
    txn(7'd15, 1'b1, 8'h00, 8'h00, 16);
    txn(7'd16, 1'b1, 8'h00, 8'h00, 16);
    txn(7'd127, 1'b1, 8'h00, 8'h00, 16);
    txn(7'd16, 1'b0, 8'hFF, 8'h00, 16);
    txn(7'd0, 1'b1, 8'h00, 8'h00, 16);
    txn(7'd5, 1'b1, 8'hFF, 8'h00, 16);
    txn(7'd5, 1'b1, 8'h00, 8'h00, 16);
    txn(7'd6, 1'b0, 8'h77, 8'h00, 12);
    txn(7'd6, 1'b0, 8'h77, 8'h00, 5);
    txn(7'd6, 1'b1, 8'h00, 8'h00, 16);
    txn(7'd7, 1'b0, 8'h81, 8'h5A, 24);
    txn(7'd7, 1'b1, 8'h00, 8'h00, 24);
    for (int n = 0; n < 24; n++) begin
      logic [6:0] a;
      a = 7'($urandom_range(0, 20));
      txn(a, 1'($urandom_range(0, 1)), 8'($urandom), 8'h00, 16);
    end
    for (int a = 0; a < 16; a++) txn(7'(a), 1'b1, 8'h00, 8'h00, 16);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule